// File: doc/BRIEF.md
# Destination-Partitioned Edge Crossbar

This block sits between a set of source-side streams, each producing graph edges, and a set of destination-side streams, each of which owns a slice of the vertex id space. An edge is a tuple of source vertex id, destination vertex id and weight. The crossbar delivers every edge to the destination stream that owns its destination vertex. A destination stream owns the vertices whose low id bits equal its own index, so no two destination streams ever touch the same vertex.

Each input keeps one small queue for every output. A stalled output therefore fills only the queues that point at it, and the input keeps accepting edges bound for other outputs. Each output picks among the inputs that hold data for it with a rotating priority and moves at most one edge per cycle. Both sides use a valid/ready handshake; an edge moves when valid and ready are high at the same rising clock edge.

Top module: `edge_xbar`

## Requirements
- R1: After reset all output valids are low and all input readies are high.
- R2: An edge leaves on the output whose index equals the low log2(N_DST) bits (bits [1:0] for 4 outputs) of its destination id, with its source id, destination id and weight unchanged.
- R3: An input's ready is low exactly when the queue for the output addressed by its current destination id is full; an edge for another output with a non-full queue is still accepted in that cycle.
- R4: Edges taken by one input and bound for one output leave that output in the order they were taken.
- R5: When several inputs hold data for one output and the output takes an edge every cycle, the winning input index rotates: after input g wins, the next winner is the first requesting input at g+1, g+2, ... wrapping around.
- R6: While an output holds valid high and its ready is low, valid stays high and the offered edge stays unchanged in the next cycle.
- R7: An edge taken into an empty queue is offered at its output in the cycle after the accepting edge, and an output whose queues hold data delivers one edge in every cycle its ready is high.
- R8: Each per-input, per-output queue holds exactly VOQ_DEPTH (4) edges; a fifth edge for a stalled output is refused until one leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_SRC | Per-input edge valid |
| in_src_i | input | N_SRC*ID_W | Per-input source vertex id, input i at bits [i*ID_W +: ID_W] |
| in_dst_i | input | N_SRC*ID_W | Per-input destination vertex id |
| in_wgt_i | input | N_SRC*WGT_W | Per-input edge weight |
| in_ready_o | output | N_SRC | Per-input ready |
| out_valid_o | output | N_DST | Per-output edge valid |
| out_src_o | output | N_DST*ID_W | Per-output source vertex id |
| out_dst_o | output | N_DST*ID_W | Per-output destination vertex id |
| out_wgt_o | output | N_DST*WGT_W | Per-output edge weight |
| out_ready_i | input | N_DST | Per-output ready |

## Verification
The case that matters is an input being refused because one of its queues is full while, in the same cycle, it hands an edge for a different output into a free queue and that other output delivers. The bench stalls output 0, fills the input's queue for it, checks that ready drops and that the offered edge on output 0 is frozen, then switches the destination to output 1 and judges that the edge is accepted at once and appears on output 1 the next cycle while output 0 is still stalled. A long pseudo-random phase mixes stalls, contention and routing on all outputs and a scoreboard checks every delivered edge for routing, payload and per-pair order.

// File: rtl/edge_xbar_pkg.sv
package edge_xbar_pkg;
  parameter int ID_W  = 32;
  parameter int WGT_W = 32;

  typedef struct packed {
    logic [ID_W-1:0]  src;
    logic [ID_W-1:0]  dst;
    logic [WGT_W-1:0] wgt;
  } edge_t;

  localparam int EDGE_W = $bits(edge_t);
endpackage

// File: rtl/edge_xbar_fifo.sv
module edge_xbar_fifo #(
  parameter int W     = 96,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (!push_i && pop_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/edge_xbar_rr_arb.sv
module edge_xbar_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] ptr_q, hold_idx_q, rr_idx;
  logic          hold_q;

  // first requester at or after the priority pointer
  always_comb begin
    logic found;
    found  = 1'b0;
    rr_idx = '0;
    for (int off = 0; off < N; off++) begin
      int c;
      c = int'(ptr_q) + off;
      if (c >= N) c = c - N;
      if (!found && req_i[c]) begin
        found  = 1'b1;
        rr_idx = IW'(c);
      end
    end
  end

  assign valid_o = |req_i;
  // keep the offered edge fixed while the output is stalled
  assign idx_o   = hold_q ? hold_idx_q : rr_idx;
  assign gnt_o   = valid_o ? (N'(1) << idx_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else if (valid_o && ready_i) begin
      ptr_q  <= (idx_o == IW'(N - 1)) ? '0 : idx_o + 1'b1;
      hold_q <= 1'b0;
    end else if (valid_o) begin
      hold_q     <= 1'b1;
      hold_idx_q <= idx_o;
    end
  end
endmodule

// File: rtl/edge_xbar_ingress.sv
module edge_xbar_ingress
  import edge_xbar_pkg::*;
#(
  parameter int N_DST     = 4,
  parameter int VOQ_DEPTH = 4,
  localparam int DW = (N_DST > 1) ? $clog2(N_DST) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  edge_t                  edge_i,
  output logic                   ready_o,
  input  logic [N_DST-1:0]       pop_i,
  output edge_t [N_DST-1:0]      head_o,
  output logic  [N_DST-1:0]      avail_o
);
  logic [DW-1:0]    route;
  logic [N_DST-1:0] full, empty, push;

  assign route   = edge_i.dst[DW-1:0];
  assign ready_o = !full[route];

  for (genvar k = 0; k < N_DST; k++) begin : g_voq
    logic [EDGE_W-1:0] dout;
    assign push[k] = valid_i && (route == DW'(k)) && !full[k];
    edge_xbar_fifo #(.W(EDGE_W), .DEPTH(VOQ_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (push[k]),
      .data_i  (edge_i),
      .pop_i   (pop_i[k]),
      .data_o  (dout),
      .empty_o (empty[k]),
      .full_o  (full[k])
    );
    assign head_o[k]  = edge_t'(dout);
    assign avail_o[k] = !empty[k];
  end
endmodule

// File: rtl/edge_xbar.sv
module edge_xbar
  import edge_xbar_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int N_DST     = 4,
  parameter int VOQ_DEPTH = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       in_valid_i,
  input  logic [N_SRC*ID_W-1:0]  in_src_i,
  input  logic [N_SRC*ID_W-1:0]  in_dst_i,
  input  logic [N_SRC*WGT_W-1:0] in_wgt_i,
  output logic [N_SRC-1:0]       in_ready_o,
  output logic [N_DST-1:0]       out_valid_o,
  output logic [N_DST*ID_W-1:0]  out_src_o,
  output logic [N_DST*ID_W-1:0]  out_dst_o,
  output logic [N_DST*WGT_W-1:0] out_wgt_o,
  input  logic [N_DST-1:0]       out_ready_i
);
  localparam int SW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  edge_t                in_edge   [N_SRC];
  edge_t [N_DST-1:0]    voq_head  [N_SRC];
  logic  [N_DST-1:0]    voq_avail [N_SRC];
  logic  [N_DST-1:0]    voq_pop   [N_SRC];
  logic  [N_SRC-1:0]    arb_req   [N_DST];
  logic  [N_SRC-1:0]    arb_gnt   [N_DST];
  logic  [SW-1:0]       arb_idx   [N_DST];

  for (genvar i = 0; i < N_SRC; i++) begin : g_in
    assign in_edge[i].src = in_src_i[i*ID_W +: ID_W];
    assign in_edge[i].dst = in_dst_i[i*ID_W +: ID_W];
    assign in_edge[i].wgt = in_wgt_i[i*WGT_W +: WGT_W];

    edge_xbar_ingress #(.N_DST(N_DST), .VOQ_DEPTH(VOQ_DEPTH)) u_ingress (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (in_valid_i[i]),
      .edge_i  (in_edge[i]),
      .ready_o (in_ready_o[i]),
      .pop_i   (voq_pop[i]),
      .head_o  (voq_head[i]),
      .avail_o (voq_avail[i])
    );

    for (genvar k = 0; k < N_DST; k++) begin : g_x
      assign arb_req[k][i] = voq_avail[i][k];
      assign voq_pop[i][k] = arb_gnt[k][i] & out_ready_i[k];
    end
  end

  for (genvar k = 0; k < N_DST; k++) begin : g_out
    edge_t sel;
    edge_xbar_rr_arb #(.N(N_SRC)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (arb_req[k]),
      .ready_i (out_ready_i[k]),
      .valid_o (out_valid_o[k]),
      .gnt_o   (arb_gnt[k]),
      .idx_o   (arb_idx[k])
    );
    assign sel = voq_head[arb_idx[k]][k];
    assign out_src_o[k*ID_W +: ID_W]   = sel.src;
    assign out_dst_o[k*ID_W +: ID_W]   = sel.dst;
    assign out_wgt_o[k*WGT_W +: WGT_W] = sel.wgt;
  end
endmodule

// File: rtl/edge_xbar_chk.sv
module edge_xbar_chk
  import edge_xbar_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int N_DST     = 4,
  parameter int VOQ_DEPTH = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC-1:0]       in_valid_i,
  input logic [N_SRC*ID_W-1:0]  in_src_i,
  input logic [N_SRC*ID_W-1:0]  in_dst_i,
  input logic [N_SRC*WGT_W-1:0] in_wgt_i,
  input logic [N_SRC-1:0]       in_ready_o,
  input logic [N_DST-1:0]       out_valid_o,
  input logic [N_DST*ID_W-1:0]  out_src_o,
  input logic [N_DST*ID_W-1:0]  out_dst_o,
  input logic [N_DST*WGT_W-1:0] out_wgt_o,
  input logic [N_DST-1:0]       out_ready_i
);
  localparam int DW = (N_DST > 1) ? $clog2(N_DST) : 1;

  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_valid_o == '0) && (in_ready_o == '1));

  for (genvar k = 0; k < N_DST; k++) begin : g_o
    assert_route_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[k] |-> (out_dst_o[k*ID_W +: DW] == DW'(k)));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o[k] && !out_ready_i[k]) |=> out_valid_o[k]
        && $stable(out_src_o[k*ID_W +: ID_W])
        && $stable(out_dst_o[k*ID_W +: ID_W])
        && $stable(out_wgt_o[k*WGT_W +: WGT_W]));
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_i
    // a refused edge implies its target queue is full, hence offered
    assert_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i[i] && !in_ready_o[i]) |-> out_valid_o[in_dst_i[i*ID_W +: DW]]);
  end
endmodule

bind edge_xbar edge_xbar_chk #(
  .N_SRC(N_SRC), .N_DST(N_DST), .VOQ_DEPTH(VOQ_DEPTH)
) u_chk (.*);

// File: tb/edge_xbar_tb.sv
module edge_xbar_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int ND = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NS-1:0] in_valid_i = '0;
  logic [NS*32-1:0] in_src_i = '0, in_dst_i = '0, in_wgt_i = '0;
  logic [NS-1:0] in_ready_o;
  logic [ND-1:0] out_valid_o;
  logic [ND*32-1:0] out_src_o, out_dst_o, out_wgt_o;
  logic [ND-1:0] out_ready_i = '0;

  edge_xbar dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [NS-1:0] drv_en = '0;
  int drv_out [NS];
  logic [ND-1:0] rdy = '0;
  int snd_seq [NS][ND];
  int exp_seq [NS][ND];
  int acc_tot = 0, dlv_tot = 0;
  logic [NS-1:0] last_ready;
  logic [31:0] snap_src [ND], snap_dst [ND], snap_wgt [ND];
  logic [ND-1:0] snap_vld;
  bit rr_mode = 0;
  int rr_log [32];
  int rr_n = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  function automatic logic [31:0] mk_dst(int i, int k, int s);
    return 32'(k + 4 * (((s * 7) + (i * 3)) & 16'hffff));
  endfunction
  function automatic logic [31:0] mk_wgt(logic [31:0] s, logic [31:0] d);
    return (s * 32'h9e37) ^ {d[15:0], d[31:16]};
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic score(int k);
    logic [31:0] s, d, w;
    int i, q;
    bit ok;
    s = out_src_o[k*32 +: 32];
    d = out_dst_o[k*32 +: 32];
    w = out_wgt_o[k*32 +: 32];
    i = int'(s[31:16]);
    q = int'(s[15:0]);
    ok = (d[1:0] == 2'(k)) && (w == mk_wgt(s, d)) && (i < NS);
    chk(ok, "R2 route/payload", int'(d[1:0]), k);
    if (i < NS) begin
      chk(q == exp_seq[i][k], "R4 order", q, exp_seq[i][k]);
      exp_seq[i][k]++;
    end
    if (rr_mode && k == 2 && rr_n < 32) begin
      rr_log[rr_n] = i;
      rr_n++;
    end
    dlv_tot++;
  endtask

  task automatic cycle();
    @(negedge clk_i);
    for (int i = 0; i < NS; i++) begin
      logic [31:0] s, d;
      s = (32'(i) << 16) | 32'(snd_seq[i][drv_out[i]] & 16'hffff);
      d = mk_dst(i, drv_out[i], snd_seq[i][drv_out[i]]);
      in_valid_i[i] = drv_en[i];
      in_src_i[i*32 +: 32] = s;
      in_dst_i[i*32 +: 32] = d;
      in_wgt_i[i*32 +: 32] = mk_wgt(s, d);
    end
    out_ready_i = rdy;
    #1;
    last_ready = in_ready_o;
    snap_vld = out_valid_o;
    for (int k = 0; k < ND; k++) begin
      snap_src[k] = out_src_o[k*32 +: 32];
      snap_dst[k] = out_dst_o[k*32 +: 32];
      snap_wgt[k] = out_wgt_o[k*32 +: 32];
    end
    for (int i = 0; i < NS; i++)
      if (in_valid_i[i] && in_ready_o[i]) begin
        snd_seq[i][drv_out[i]]++;
        acc_tot++;
      end
    for (int k = 0; k < ND; k++)
      if (out_valid_o[k] && out_ready_i[k]) score(k);
    @(posedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int base, d0, b1;
    logic [31:0] h_src, h_dst, h_wgt;
    for (int i = 0; i < NS; i++) begin
      drv_out[i] = 0;
      for (int k = 0; k < ND; k++) begin
        snd_seq[i][k] = 0;
        exp_seq[i][k] = 0;
      end
    end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(out_valid_o == '0, "R1 out_valid", int'(out_valid_o), 0);
    chk(in_ready_o == 4'hf, "R1 in_ready", int'(in_ready_o), 15);

    // every input to every output, latency check
    rdy = 4'hf;
    for (int i = 0; i < NS; i++)
      for (int k = 0; k < ND; k++) begin
        drv_en = 4'(1 << i);
        drv_out[i] = k;
        cycle();
        drv_en = '0;
        d0 = dlv_tot;
        cycle();
        chk(dlv_tot == d0 + 1, "R7 latency", dlv_tot - d0, 1);
      end

    // stall output 0, fill input 0's queue, then bypass to output 1
    rdy = 4'b1110;
    drv_en = 4'b0001;
    drv_out[0] = 0;
    base = snd_seq[0][0];
    cycle(); cycle();
    h_src = snap_src[0]; h_dst = snap_dst[0]; h_wgt = snap_wgt[0];
    repeat (6) cycle();
    chk(snd_seq[0][0] - base == 4, "R8 depth", snd_seq[0][0] - base, 4);
    chk(last_ready[0] == 1'b0, "R3 ready low when full", int'(last_ready[0]), 0);
    chk(snap_vld[0] && snap_src[0] == h_src && snap_dst[0] == h_dst && snap_wgt[0] == h_wgt,
        "R6 held edge", int'(snap_src[0]), int'(h_src));
    drv_out[0] = 1;
    b1 = snd_seq[0][1];
    cycle();
    chk(snd_seq[0][1] == b1 + 1, "R3 other output accepted", snd_seq[0][1] - b1, 1);
    drv_en = '0;
    d0 = dlv_tot;
    cycle();
    chk(dlv_tot == d0 + 1 && snap_vld[0], "R3 bypass delivered", dlv_tot - d0, 1);
    rdy = 4'hf;
    repeat (8) cycle();
    chk(exp_seq[0][0] == snd_seq[0][0], "R8 all delivered", exp_seq[0][0], snd_seq[0][0]);

    // contention on output 2
    rdy = 4'b1011;
    drv_en = 4'hf;
    for (int i = 0; i < NS; i++) drv_out[i] = 2;
    for (int i = 0; i < NS; i++) snd_seq[i][3] = snd_seq[i][3];
    begin
      int b [NS];
      for (int i = 0; i < NS; i++) b[i] = snd_seq[i][2];
      repeat (6) cycle();
      for (int i = 0; i < NS; i++)
        chk(snd_seq[i][2] - b[i] == 4, "R8 depth per input", snd_seq[i][2] - b[i], 4);
    end
    drv_en = '0;
    rr_mode = 1;
    rr_n = 0;
    rdy = 4'hf;
    repeat (16) cycle();
    rr_mode = 0;
    chk(rr_n == 16, "R7 one per cycle", rr_n, 16);
    for (int j = 1; j < 16; j++)
      chk(rr_log[j] == (rr_log[j-1] + 1) % NS, "R5 rotation", rr_log[j], (rr_log[j-1] + 1) % NS);

    // pseudo-random traffic
    for (int c = 0; c < 4000; c++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      drv_en = lfsr[3:0];
      for (int i = 0; i < NS; i++) drv_out[i] = int'(lfsr[8 + 2*i +: 2]);
      rdy = lfsr[20 +: 4] | lfsr[26 +: 4];
      cycle();
    end
    drv_en = '0;
    rdy = 4'hf;
    repeat (24) cycle();
    chk(dlv_tot == acc_tot, "R4 no loss", dlv_tot, acc_tot);
    for (int i = 0; i < NS; i++)
      for (int k = 0; k < ND; k++)
        chk(exp_seq[i][k] == snd_seq[i][k], "R4 pair count", exp_seq[i][k], snd_seq[i][k]);
    finish_run();
  end
endmodule